// File: doc/BRIEF.md
# Programmable Conversion Pacing Timer

This block sets the spacing between successive analog conversions. A host writes a 16-bit start value into a pace register. Each conversion run of the built-in sequencer copies that value into a loadable up-counter while an active-low load/count control is asserted. Once the control is released, the counter advances by one on every system-clock edge toward all-ones. The counter is built from four cascaded 4-bit stages.

An active-low end-of-count flag drops when the counter reaches all-ones. It stays low until the next load. The sequencer reaches a pacing checkpoint at cycle 15. If internal pacing is enabled and the flag is still high at that point, the sequencer holds there until the flag drops. A start value of FFF6 hex minus n therefore gives a conversion-to-conversion period of 30 + n clocks when requests are back to back. In the host's terms, n is round((period − 18 µs) / 0.6 µs) at a 600 ns clock.

Requests are accepted only while the block is not busy. One further request may wait behind a running conversion and starts right after that conversion's last cycle.

Top module: `pace_timer`

## Requirements
- R1: A write strobe stores the 16-bit write data in the pace register. The stored value is kept across any number of conversions until the next write, and reset clears it to 0.
- R2: After reset the counter reads 0, the end-of-count flag is high, the sequencer is idle, and busy, stall, both strobes and the inverted load control are inactive (load control high).
- R3: In any cycle where the load control is low, the next clock loads the counter with the pace register value.
- R4: In any cycle where the load control is high, the next clock adds one to the counter, and FFFF wraps to 0. Stage k (bits 4k+3..4k) advances only when every lower stage holds all-ones.
- R5: The end-of-count flag is high while the load control is low. While counting, it goes low in the first cycle the counter reads FFFF. It then stays low until the load control goes low again, including after the counter wraps.
- R6: A conversion runs sequencer cycles 0 to 28, with cycle 0 starting one clock after the request is accepted. The sample strobe is high in cycle 3, the load control is low in cycles 4 to 6, and the latch strobe is high in cycle 5. Busy is high in cycles 0 to 5, so counting runs from cycle 7.
- R7: In cycle 15, if the end-of-count flag is high and the pace-disable input is low, stall is high and the sequencer holds cycle 15. It advances on the clock after the flag has gone low. With start value FFF6 minus n (n ≥ 0), back-to-back conversions start every 30 + n clocks.
- R8: While the pace-disable input is high, stall never asserts and back-to-back conversions start every 29 clocks.
- R9: With start values FFF7 to FFFF the flag is already low by cycle 15, so no stall occurs and the period is 29 clocks.
- R10: A request raised while busy is high is ignored. A request accepted after cycle 5 starts the next conversion immediately after cycle 28. With no request, the sequencer goes idle after cycle 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one count per period |
| rst_n | input | 1 | Active-low synchronous reset |
| pace_wr | input | 1 | Host write strobe for the pace register |
| pace_wdata | input | 16 | Start value written to the pace register |
| conv_req | input | 1 | Conversion request (accepted when busy is low) |
| int_pace_dis | input | 1 | High disables internal pacing (external pacing mode) |
| busy | output | 1 | Request held or conversion in cycles 0 to 5 |
| sample_stb | output | 1 | Sample strobe, sequencer cycle 3 |
| load_n | output | 1 | Load/count control, low loads the counter |
| latch_stb | output | 1 | Latch strobe, sequencer cycle 5 |
| end_cnt_n | output | 1 | End-of-count flag, active low |
| stall | output | 1 | Sequencer held at the pacing checkpoint |
| seq_active | output | 1 | Sequencer running a conversion |
| seq_cyc | output | 5 | Current sequencer cycle |
| pace_cnt | output | 16 | Pacing counter value |

## Verification
The bench measures start-to-start periods over a table of start values. The table covers the value that gives exactly one stall cycle, small and large stalls, the window FFF7 to FFFF where the flag is already low at the checkpoint, and the external-pacing mode. A design that raised the flag on wrap instead of at FFFF, or that let it rise again after wrapping, would show periods of roughly 65 thousand clocks or be off by one. Directed runs check the exact cycles of the strobes, load window and busy edge. They also count the stalled cycles and check that the flag stays low after the counter wraps. Finally, they check that a request raised while busy is dropped: a design that queued it would start an unwanted extra conversion.

// File: rtl/pace_timer.sv
module pace_timer #(
  parameter int STAGES     = 4,
  parameter int STAGE_W    = 4,
  parameter int SAMPLE_CYC = 3,
  parameter int CHECK_CYC  = 15,
  parameter int LAST_CYC   = 28
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pace_wr,
  input  logic [STAGES*STAGE_W-1:0]     pace_wdata,
  input  logic                          conv_req,
  input  logic                          int_pace_dis,
  output logic                          busy,
  output logic                          sample_stb,
  output logic                          load_n,
  output logic                          latch_stb,
  output logic                          end_cnt_n,
  output logic                          stall,
  output logic                          seq_active,
  output logic [$clog2(LAST_CYC+1)-1:0] seq_cyc,
  output logic [STAGES*STAGE_W-1:0]     pace_cnt
);

  localparam int CNT_W = STAGES * STAGE_W;
  localparam int CYC_W = $clog2(LAST_CYC + 1);
  localparam logic [CYC_W-1:0] C_SAMPLE = CYC_W'(SAMPLE_CYC);
  localparam logic [CYC_W-1:0] C_LOAD0  = CYC_W'(SAMPLE_CYC + 1);
  localparam logic [CYC_W-1:0] C_LATCH  = CYC_W'(SAMPLE_CYC + 2);
  localparam logic [CYC_W-1:0] C_LOAD1  = CYC_W'(SAMPLE_CYC + 3);
  localparam logic [CYC_W-1:0] C_CHECK  = CYC_W'(CHECK_CYC);
  localparam logic [CYC_W-1:0] C_LAST   = CYC_W'(LAST_CYC);

  logic [CNT_W-1:0] pace_reg;
  logic [STAGES:0]  carry;
  logic             hit_q;
  logic             pending_q;
  logic             accept;
  logic             start;

  always_ff @(posedge clk) begin
    if (!rst_n)       pace_reg <= '0;
    else if (pace_wr) pace_reg <= pace_wdata;
  end

  assign carry[0] = load_n;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [STAGE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (!load_n)  q <= pace_reg[k*STAGE_W +: STAGE_W];
      else if (carry[k]) q <= q + 1'b1;
    end
    assign carry[k+1] = carry[k] & (&q);
    assign pace_cnt[k*STAGE_W +: STAGE_W] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !load_n) hit_q <= 1'b0;
    else if (carry[STAGES]) hit_q <= 1'b1;
  end

  assign end_cnt_n = ~(carry[STAGES] | (load_n & hit_q));

  assign accept = conv_req & ~busy;
  assign start  = (accept | pending_q) & (~seq_active | (seq_cyc == C_LAST & ~stall));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_active <= 1'b0;
      seq_cyc    <= '0;
      pending_q  <= 1'b0;
    end else begin
      if (start) begin
        seq_active <= 1'b1;
        seq_cyc    <= '0;
      end else if (seq_active && !stall) begin
        if (seq_cyc == C_LAST) seq_active <= 1'b0;
        else                   seq_cyc    <= seq_cyc + 1'b1;
      end
      if (start)       pending_q <= 1'b0;
      else if (accept) pending_q <= 1'b1;
    end
  end

  assign busy       = pending_q | (seq_active & (seq_cyc <= C_LATCH));
  assign sample_stb = seq_active & (seq_cyc == C_SAMPLE);
  assign latch_stb  = seq_active & (seq_cyc == C_LATCH);
  assign load_n     = ~(seq_active & (seq_cyc >= C_LOAD0) & (seq_cyc <= C_LOAD1));
  assign stall      = seq_active & (seq_cyc == C_CHECK) & end_cnt_n & ~int_pace_dis;

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> pace_cnt == $past(pace_reg)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> pace_cnt == CNT_W'($past(pace_cnt) + 1'b1)); // R4
  AST_FLAG_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && (&pace_cnt)) |-> !end_cnt_n); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_cnt_n && load_n) |=> (!end_cnt_n || !load_n)); // R5
  AST_FLAG_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> end_cnt_n); // R5
  AST_SAMPLE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (!load_n && !latch_stb)); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (seq_active && seq_cyc == $past(seq_cyc))); // R7
  AST_NO_STALL_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    int_pace_dis |-> !stall); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !busy) |=> (busy || seq_active)); // R10

endmodule

// File: tb/pace_timer_test.sv
module pace_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 8;
  // {start value, pace disable, expected period}
  localparam logic [32:0] VEC [NVEC] = '{
    {16'hFFF6, 1'b0, 16'd30},
    {16'hFFF0, 1'b0, 16'd36},
    {16'hFF00, 1'b0, 16'd276},
    {16'hFFF3, 1'b0, 16'd33},
    {16'hFFF7, 1'b0, 16'd29},
    {16'hFFFB, 1'b0, 16'd29},
    {16'hFFFF, 1'b0, 16'd29},
    {16'hFF00, 1'b1, 16'd29}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pace_wr = 1'b0;
  logic [15:0] pace_wdata = '0;
  logic conv_req = 1'b0;
  logic int_pace_dis = 1'b0;
  logic busy, sample_stb, load_n, latch_stb, end_cnt_n, stall, seq_active;
  logic [4:0] seq_cyc;
  logic [15:0] pace_cnt;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  pace_timer uut (
    .clk(clk), .rst_n(rst_n), .pace_wr(pace_wr), .pace_wdata(pace_wdata),
    .conv_req(conv_req), .int_pace_dis(int_pace_dis), .busy(busy),
    .sample_stb(sample_stb), .load_n(load_n), .latch_stb(latch_stb),
    .end_cnt_n(end_cnt_n), .stall(stall), .seq_active(seq_active),
    .seq_cyc(seq_cyc), .pace_cnt(pace_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    do @(negedge clk); while (!(seq_active && seq_cyc == 5'(n)));
  endtask

  task automatic wait_idle();
    while (seq_active || busy) @(negedge clk);
  endtask

  task automatic write_pace(input logic [15:0] v);
    pace_wr = 1'b1;
    pace_wdata = v;
    @(negedge clk);
    pace_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int t0, t1, stalls;
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2", "pace_cnt", pace_cnt, 0);
    check("R2", "end_cnt_n", end_cnt_n, 1);
    check("R2", "seq_active", seq_active, 0);
    check("R2", "busy", busy, 0);
    check("R2", "load_n", load_n, 1);
    check("R2", "stall", stall, 0);
    check("R2", "strobes", {sample_stb, latch_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset value of pace register seen through the load
    int_pace_dis = 1'b1;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    wait_cyc(7);
    check("R1", "reset pace value loaded", pace_cnt, 0);
    wait_idle();
    int_pace_dis = 1'b0;

    // table of start values and expected periods: R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      wait_idle();
      write_pace(VEC[i][32:17]);
      int_pace_dis = VEC[i][16];
      conv_req = 1'b1;
      wait_cyc(0);
      t0 = cyc_cnt;
      wait_cyc(7);
      conv_req = 1'b0;
      wait_cyc(0);
      t1 = cyc_cnt;
      if (VEC[i][16])
        check("R8", "period with pacing disabled", t1 - t0, int'(VEC[i][15:0]));
      else if (VEC[i][32:17] > 16'hFFF6)
        check("R9", "period for top start value", t1 - t0, int'(VEC[i][15:0]));
      else
        check("R7", "paced period", t1 - t0, int'(VEC[i][15:0]));
      wait_idle();
    end
    int_pace_dis = 1'b0;

    // directed run, start value FFF0: R3 R4 R5 R6 R7 R10
    write_pace(16'hFFF0);
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    check("R6", "cycle 0 one clock after accept", {seq_active, seq_cyc}, {1'b1, 5'd0});
    check("R6", "busy in cycle 0", busy, 1);
    wait_cyc(2);
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    check("R6", "sample strobe cycle 3", sample_stb, 1);
    wait_cyc(4);
    check("R6", "load_n low cycle 4", load_n, 0);
    check("R5", "flag high during load", end_cnt_n, 1);
    wait_cyc(5);
    check("R6", "latch strobe cycle 5", latch_stb, 1);
    check("R6", "busy in cycle 5", busy, 1);
    wait_cyc(6);
    check("R6", "busy low cycle 6", busy, 0);
    check("R6", "load_n low cycle 6", load_n, 0);
    wait_cyc(7);
    check("R6", "load_n high cycle 7", load_n, 1);
    check("R3", "loaded start value", pace_cnt, 16'hFFF0);
    @(negedge clk);
    check("R4", "first increment", pace_cnt, 16'hFFF1);
    wait_cyc(15);
    check("R7", "stall at checkpoint", stall, 1);
    check("R4", "count at checkpoint", pace_cnt, 16'hFFF8);
    stalls = 0;
    while (stall && stalls < 100) begin
      stalls++;
      @(negedge clk);
    end
    check("R7", "stalled cycles", stalls, 7);
    check("R7", "still at checkpoint", seq_cyc, 15);
    check("R5", "flag low at FFFF", end_cnt_n, 0);
    check("R5", "count at flag", pace_cnt, 16'hFFFF);
    @(negedge clk);
    check("R7", "advanced past checkpoint", seq_cyc, 16);
    check("R4", "wrap to zero", pace_cnt, 0);
    check("R5", "flag stays low after wrap", end_cnt_n, 0);
    @(negedge clk);
    check("R5", "flag low two cycles after wrap", end_cnt_n, 0);
    wait_idle();
    repeat (4) @(negedge clk);
    check("R10", "request while busy ignored", seq_active, 0);

    // R1 value held across conversions
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    wait_cyc(7);
    check("R1", "pace value held", pace_cnt, 16'hFFF0);
    wait_idle();

    done = 1'b1;
    finish_run();
  end
endmodule